// File: doc/BRIEF.md
# Byte-Packing I2C Data FIFO

This block sits between a host that moves data only as 16-bit words and a serial shift engine that moves one byte at a time. It holds two independent byte queues of four bytes each (two host words). On the transmit side, every accepted host write adds two bytes, and the engine pops them one at a time. On the receive side, the engine pushes bytes one at a time and the host reads them back as packed 16-bit words.

A single endianness input sets where the earlier byte of a pair sits within a word. A receive transfer that ends on an odd byte still delivers that byte. It comes as a word with a zero pad, and a status bit tells the host that only one byte in it is valid. A host write into a full transmit queue, an engine push into a full receive queue, and a host read with no word ready are all dropped, and each sets a sticky error flag. A flush input empties both queues in one cycle.

Top module: `i2c_byte_fifo`

## Requirements
- R1: After reset, tx_empty=1, tx_byte_valid=0, tx_full=0, rx_word_ready=0, rx_full=0, host_rd_data=0x0000, single_byte=0 and err=0.
- R2: Each queue holds four bytes. tx_full is 1 whenever fewer than two byte slots are free, so it is set after two accepted host writes. rx_full is 1 when four received bytes are held.
- R3: When big_end is 0 at the moment of a host write, the engine pops host_wr_data[7:0] first and [15:8] second. When big_end is 1, [15:8] comes first. A later change of big_end does not reorder bytes already written.
- R4: Once two received bytes are held, rx_word_ready is 1. A host read then returns the earlier byte in [7:0] and the later byte in [15:8] when big_end is 0, and the reverse when big_end is 1. The word appears on host_rd_data one cycle after host_rd_en, with single_byte=0.
- R5: A pulse on rx_end, either with the last byte or after it, makes a lone pending byte readable. The read returns that byte with 0x00 in [15:8] when big_end is 0, or 0x00 in [7:0] when big_end is 1, and sets single_byte to 1.
- R6: A single received byte with no end-of-transfer signal does not raise rx_word_ready.
- R7: A host write while tx_full is 1, and an engine push while rx_full is 1, are both dropped and set err.
- R8: A host read while rx_word_ready is 0 leaves host_rd_data unchanged and sets err. err stays 1 until reset.
- R9: flush empties both queues, clears single_byte and clears any end-of-transfer marker in one cycle. It leaves err as it was.
- R10: A host write and an engine pop in the same cycle are both carried out. The write is accepted if two slots were free before the pop, and byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty both queues, clear single_byte |
| big_end | input | 1 | 0: earlier byte in low half; 1: earlier byte in high half |
| host_wr_en | input | 1 | Host word write strobe |
| host_wr_data | input | 16 | Host word to transmit |
| host_rd_en | input | 1 | Host word read strobe |
| host_rd_data | output | 16 | Last word read (registered) |
| single_byte | output | 1 | Last word read held one valid byte |
| err | output | 1 | Sticky overflow / empty-read flag |
| tx_full | output | 1 | Fewer than two free transmit slots |
| tx_empty | output | 1 | Transmit queue empty |
| tx_byte | output | 8 | Byte offered to the engine |
| tx_byte_valid | output | 1 | tx_byte holds data |
| tx_pop | input | 1 | Engine takes tx_byte |
| rx_byte | input | 8 | Byte from the engine |
| rx_push | input | 1 | Engine delivers rx_byte |
| rx_end | input | 1 | Engine signals end of transfer |
| rx_word_ready | output | 1 | A host read would succeed |
| rx_full | output | 1 | Receive queue holds four bytes |

## Verification
The transmit path is driven with distinct upper and lower byte values under both endianness settings. This shows a swapped order, and it also shows whether the order is fixed at write time or at pop time. On receive, the bench reads even runs, odd runs ended by rx_end, and a run ended with the end pulse on its own. These cases separate pad placement, the single_byte flag, and readiness without an end marker. Queue-full writes and pushes, empty reads, flush and a same-cycle write and pop exercise the boundary and concurrency rules.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;

  // earlier byte goes low (le) or high (be)
  function automatic word_t pack_pair(byte_t first, byte_t second, logic be);
    return be ? {first, second} : {second, first};
  endfunction

  // lone byte with zero filler in the unused half
  function automatic word_t pack_lone(byte_t first, logic be);
    return be ? {first, 8'h00} : {8'h00, first};
  endfunction
endpackage

// File: rtl/bf_byte_ring.sv
module bf_byte_ring #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  bf_pkg::byte_t push_d0,
  input  bf_pkg::byte_t push_d1,
  input  logic [1:0]    pop_n,
  output bf_pkg::byte_t peek0,
  output bf_pkg::byte_t peek1,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  bf_pkg::byte_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push_n != 2'd0) mem[wr_ptr] <= push_d0;
      if (push_n == 2'd2) mem[wr_ptr + PW'(1)] <= push_d1;
    end
  end

  assign peek0 = mem[rd_ptr];
  assign peek1 = mem[rd_ptr + PW'(1)];

  // controllers must never ask for more than the ring can hold or give
  assert_ring_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    !clr |-> ((int'(count) + int'(push_n) <= DEPTH + int'(pop_n)) &&
              (int'(pop_n) <= int'(count))));
endmodule

// File: rtl/bf_tx_side.sv
module bf_tx_side #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          big_end,
  input  logic          wr_en,
  input  bf_pkg::word_t wr_data,
  input  logic          pop,
  input  logic [CW-1:0] count,
  input  bf_pkg::byte_t peek0,
  output logic [1:0]    push_n,
  output bf_pkg::byte_t d0,
  output bf_pkg::byte_t d1,
  output logic [1:0]    pop_n,
  output logic          wr_err,
  output logic          full,
  output logic          empty
);
  logic room2, wr_ok;

  always_comb begin
    room2  = int'(count) <= DEPTH - 2;
    wr_ok  = wr_en && room2 && !flush;
    full   = !room2;
    empty  = count == '0;
    d0     = big_end ? wr_data[15:8] : wr_data[7:0];
    d1     = big_end ? wr_data[7:0]  : wr_data[15:8];
    push_n = wr_ok ? 2'd2 : 2'd0;
    pop_n  = (pop && !empty && !flush) ? 2'd1 : 2'd0;
    wr_err = wr_en && !room2 && !flush;
  end

  // byte order chosen at write time (R3)
  assert_tx_first_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && count == '0) |=>
      (peek0 == ($past(big_end) ? $past(wr_data[15:8]) : $past(wr_data[7:0]))));
endmodule

// File: rtl/bf_rx_side.sv
module bf_rx_side #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          big_end,
  input  logic          push,
  input  logic          end_in,
  input  logic          rd_en,
  input  logic [CW-1:0] count,
  input  bf_pkg::byte_t peek0,
  input  bf_pkg::byte_t peek1,
  output logic [1:0]    push_n,
  output logic [1:0]    pop_n,
  output bf_pkg::word_t rd_data,
  output logic          single,
  output logic          rd_err,
  output logic          push_err,
  output logic          word_ready,
  output logic          full
);
  logic end_flag, take2, rd_ok;

  always_comb begin
    full       = int'(count) == DEPTH;
    take2      = int'(count) >= 2;
    word_ready = take2 || (count == CW'(1) && end_flag);
    rd_ok      = rd_en && word_ready && !flush;
    push_n     = (push && !full && !flush) ? 2'd1 : 2'd0;
    pop_n      = rd_ok ? (take2 ? 2'd2 : 2'd1) : 2'd0;
    rd_err     = rd_en && !word_ready && !flush;
    push_err   = push && full && !flush;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      single   <= 1'b0;
      end_flag <= 1'b0;
    end else if (flush) begin
      single   <= 1'b0;
      end_flag <= 1'b0;
    end else begin
      if (rd_ok) begin
        rd_data <= take2 ? bf_pkg::pack_pair(peek0, peek1, big_end)
                         : bf_pkg::pack_lone(peek0, big_end);
        single  <= !take2;
      end
      if (end_in) end_flag <= 1'b1;
      else if (rd_ok && int'(count) == int'(pop_n)) end_flag <= 1'b0;
    end
  end

  assert_lone_pad_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && count == CW'(1)) |=>
      (single && (($past(big_end) ? rd_data[7:0] : rd_data[15:8]) == 8'h00)));

  assert_pair_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && take2) |=> !single);

  assert_rd_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !word_ready && !flush) |=> $stable(rd_data));
endmodule

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int WORDS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        big_end,
  input  logic        host_wr_en,
  input  logic [15:0] host_wr_data,
  input  logic        host_rd_en,
  output logic [15:0] host_rd_data,
  output logic        single_byte,
  output logic        err,
  output logic        tx_full,
  output logic        tx_empty,
  output logic [7:0]  tx_byte,
  output logic        tx_byte_valid,
  input  logic        tx_pop,
  input  logic [7:0]  rx_byte,
  input  logic        rx_push,
  input  logic        rx_end,
  output logic        rx_word_ready,
  output logic        rx_full
);
  localparam int DEPTH = 2 * WORDS;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [1:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  bf_pkg::byte_t tx_d0, tx_d1, tx_peek1, rx_peek0, rx_peek1;
  logic [CW-1:0] tx_count, rx_count;
  logic          wr_err, rd_err, push_err;

  bf_byte_ring #(.DEPTH(DEPTH), .CW(CW)) u_tx_ring (
    .clk(clk), .rst(rst), .clr(flush),
    .push_n(tx_push_n), .push_d0(tx_d0), .push_d1(tx_d1),
    .pop_n(tx_pop_n), .peek0(tx_byte), .peek1(tx_peek1), .count(tx_count));

  bf_tx_side #(.DEPTH(DEPTH), .CW(CW)) u_tx_side (
    .clk(clk), .rst(rst), .flush(flush), .big_end(big_end),
    .wr_en(host_wr_en), .wr_data(host_wr_data), .pop(tx_pop),
    .count(tx_count), .peek0(tx_byte),
    .push_n(tx_push_n), .d0(tx_d0), .d1(tx_d1), .pop_n(tx_pop_n),
    .wr_err(wr_err), .full(tx_full), .empty(tx_empty));

  bf_byte_ring #(.DEPTH(DEPTH), .CW(CW)) u_rx_ring (
    .clk(clk), .rst(rst), .clr(flush),
    .push_n(rx_push_n), .push_d0(rx_byte), .push_d1(8'h00),
    .pop_n(rx_pop_n), .peek0(rx_peek0), .peek1(rx_peek1), .count(rx_count));

  bf_rx_side #(.DEPTH(DEPTH), .CW(CW)) u_rx_side (
    .clk(clk), .rst(rst), .flush(flush), .big_end(big_end),
    .push(rx_push), .end_in(rx_end), .rd_en(host_rd_en),
    .count(rx_count), .peek0(rx_peek0), .peek1(rx_peek1),
    .push_n(rx_push_n), .pop_n(rx_pop_n),
    .rd_data(host_rd_data), .single(single_byte),
    .rd_err(rd_err), .push_err(push_err),
    .word_ready(rx_word_ready), .full(rx_full));

  assign tx_byte_valid = !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else if (wr_err || rd_err || push_err) err <= 1'b1;
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_empty && !rx_word_ready && !rx_full && !single_byte));

  assert_tx_second_R3: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !flush && tx_count == '0) |=>
      (tx_peek1 == ($past(big_end) ? $past(host_wr_data[7:0]) : $past(host_wr_data[15:8]))));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && tx_full && !tx_pop && !flush) |=> (tx_count == $past(tx_count)));
endmodule

// File: tb/i2c_byte_fifo_bench.sv
module i2c_byte_fifo_bench;
  logic clk = 1'b0;
  logic rst, flush, big_end, host_wr_en, host_rd_en, tx_pop, rx_push, rx_end;
  logic [15:0] host_wr_data, host_rd_data;
  logic [7:0]  rx_byte, tx_byte;
  logic single_byte, err, tx_full, tx_empty, tx_byte_valid, rx_word_ready, rx_full;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_byte_fifo u_i2c_byte_fifo (
    .clk(clk), .rst(rst), .flush(flush), .big_end(big_end),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .single_byte(single_byte), .err(err), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid),
    .tx_pop(tx_pop), .rx_byte(rx_byte), .rx_push(rx_push), .rx_end(rx_end),
    .rx_word_ready(rx_word_ready), .rx_full(rx_full));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; flush = 0; big_end = 0; host_wr_en = 0; host_rd_en = 0;
    tx_pop = 0; rx_push = 0; rx_end = 0; host_wr_data = '0; rx_byte = '0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic hwrite(logic [15:0] w);
    host_wr_en = 1; host_wr_data = w;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    b = tx_byte; tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  task automatic rpush(logic [7:0] b, logic e);
    rx_push = 1; rx_byte = b; rx_end = e;
    @(negedge clk);
    rx_push = 0; rx_end = 0;
  endtask

  task automatic hread();
    host_rd_en = 1;
    @(negedge clk);
    host_rd_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_byte_valid", tx_byte_valid, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_word_ready", rx_word_ready, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 host_rd_data", host_rd_data, 16'h0000);
    chk("R1 single_byte", single_byte, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b;
    do_reset();
    big_end = 0; hwrite(16'hA1B2);
    pop_byte(b); chk("R3 le first", b, 8'hB2);
    pop_byte(b); chk("R3 le second", b, 8'hA1);
    chk("R3 empty after pops", tx_empty, 1);
    big_end = 1; hwrite(16'h1234);
    big_end = 0;
    pop_byte(b); chk("R3 be first", b, 8'h12);
    pop_byte(b); chk("R3 be second", b, 8'h34);
    chk("R3 no error", err, 0);
  endtask

  task automatic t_tx_full();
    logic [7:0] b;
    do_reset();
    hwrite(16'h0201);
    chk("R2 one word not full", tx_full, 0);
    hwrite(16'h0403);
    chk("R2 two words full", tx_full, 1);
    hwrite(16'h0605);
    chk("R7 tx overflow err", err, 1);
    for (int i = 1; i <= 4; i++) begin
      pop_byte(b); chk("R7 tx content kept", b, 8'(i));
    end
    chk("R7 extra word dropped", tx_empty, 1);
  endtask

  task automatic t_rx_pack();
    do_reset();
    rpush(8'h11, 0);
    chk("R6 one byte not ready", rx_word_ready, 0);
    rpush(8'h22, 0);
    chk("R4 two bytes ready", rx_word_ready, 1);
    hread();
    chk("R4 le word", host_rd_data, 16'h2211);
    chk("R4 le single", single_byte, 0);
    big_end = 1;
    rpush(8'h33, 0); rpush(8'h44, 0);
    hread();
    chk("R4 be word", host_rd_data, 16'h3344);
    chk("R4 empty after read", rx_word_ready, 0);
  endtask

  task automatic t_rx_odd();
    do_reset();
    hwrite(16'h0000); // keep tx side busy, unrelated
    rpush(8'h55, 0);
    chk("R6 lone byte waits", rx_word_ready, 0);
    hread();
    chk("R8 empty read data kept", host_rd_data, 16'h0000);
    chk("R8 empty read err", err, 1);
    rx_end = 1; @(negedge clk); rx_end = 0;
    chk("R5 end pulse readies", rx_word_ready, 1);
    hread();
    chk("R5 le pad", host_rd_data, 16'h0055);
    chk("R5 le single", single_byte, 1);
    chk("R8 err sticky", err, 1);
    do_reset();
    big_end = 1;
    rpush(8'h01, 0); rpush(8'h02, 0); rpush(8'h03, 1);
    hread();
    chk("R5 be pair first", host_rd_data, 16'h0102);
    chk("R5 be pair single", single_byte, 0);
    hread();
    chk("R5 be pad", host_rd_data, 16'h0300);
    chk("R5 be single", single_byte, 1);
    rpush(8'h0A, 0); rpush(8'h0B, 0);
    hread();
    chk("R4 single cleared", single_byte, 0);
    chk("R5 no err", err, 0);
  endtask

  task automatic t_rx_full();
    do_reset();
    for (int i = 1; i <= 4; i++) rpush(8'(i), 0);
    chk("R2 rx full", rx_full, 1);
    rpush(8'h05, 0);
    chk("R7 rx overflow err", err, 1);
    hread();
    chk("R7 rx word1", host_rd_data, 16'h0201);
    hread();
    chk("R7 rx word2", host_rd_data, 16'h0403);
    chk("R7 extra byte dropped", rx_word_ready, 0);
  endtask

  task automatic t_flush();
    do_reset();
    hwrite(16'hBEEF);
    rpush(8'h77, 1);
    hread();
    chk("R9 pre single", single_byte, 1);
    rpush(8'h88, 0); rpush(8'h99, 1);
    flush = 1; @(negedge clk); flush = 0;
    chk("R9 tx empty", tx_empty, 1);
    chk("R9 rx not ready", rx_word_ready, 0);
    chk("R9 single cleared", single_byte, 0);
    chk("R9 err untouched", err, 0);
    rpush(8'h66, 0);
    chk("R9 end marker cleared", rx_word_ready, 0);
  endtask

  task automatic t_concurrent();
    logic [7:0] b;
    do_reset();
    hwrite(16'hAABB);
    chk("R10 head before", tx_byte, 8'hBB);
    host_wr_en = 1; host_wr_data = 16'hCCDD; tx_pop = 1;
    @(negedge clk);
    host_wr_en = 0; tx_pop = 0;
    chk("R10 no err", err, 0);
    pop_byte(b); chk("R10 order 1", b, 8'hAA);
    pop_byte(b); chk("R10 order 2", b, 8'hDD);
    pop_byte(b); chk("R10 order 3", b, 8'hCC);
    chk("R10 drained", tx_empty, 1);
  endtask

  initial begin
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx_pack();
    t_rx_odd();
    t_rx_full();
    t_flush();
    t_concurrent();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule